// File: doc/BRIEF.md
# Dual-Slot Warp Register Scoreboard

This block records which architectural registers still have a write in flight, per warp. Every warp owns two independent scoreboard slots, one per half of its instruction buffer. Slot 0 serves the half that primary issue and inter-warp donor issue come from. Slot 1 serves the half used by intra-warp co-issue. Because the two halves run on disjoint lanes, hazard checks look only at the named slot and never at lane masks.

Three streams drive the table: a reserve stream at issue, a release stream at writeback, and a combinational hazard query from the scheduler. Reserve and release are valid-only streams with no back-pressure. The block is always ready, so a beat presented with its valid high is taken at that rising edge. Reservations become visible one cycle after the beat. The query answers in the same cycle from the registered table. Per-slot clean flags and per-warp pending flags come straight from that table. NUM_WARPS and NUM_REGS must be powers of two, and register number 0 means "no register".

Top module: `dual_slot_scoreboard`

## Requirements
- R1: After reset every slot of every warp is empty: `slot_clean` is all ones and `warp_pending` is all zeros.
- R2: A reserve beat sets every nonzero destination number in the routed slot of `rsv_warp`, visible from the next cycle. Destinations equal to 0 are skipped.
- R3: Reserve routing by `rsv_kind` is fixed: code 0 (primary issue) goes to slot 0, code 1 (intra-warp co-issue) goes to slot 1, and code 2 (inter-warp donor) goes to slot 0 of the warp named. Code 3 is illegal and changes nothing.
- R4: A reservation is plain set membership. Reserving a register that is already present, or naming it twice in one beat, leaves the state as it is. One release then clears it.
- R5: A release clears only the named register in the named warp and slot. Releasing a register that is absent there has no effect, including on the other slot.
- R6: A release with `rel_tagged` high uses `rel_slot`, where values above 1 are illegal and ignored. With `rel_tagged` low it uses slot 1 when `rel_intra` is high and slot 0 otherwise.
- R7: `q_hit` is high in the same cycle when any nonzero operand of the query is present in the named slot. The operands are the destinations, sources, predicate and the two address registers. Operands equal to 0 never hit.
- R8: A query sees only its own slot. A register held in the other slot of the same warp does not raise `q_hit`, and a query slot above 1 returns 0.
- R9: `slot_clean[2*w+s]` is high exactly when slot s of warp w is empty. `warp_pending[w]` is high exactly when either slot of warp w is non-empty. Neither changes in a cycle with no reserve or release beat.
- R10: When a reserve and a release hit the same register of the same warp and slot in one cycle, the release is applied first, so the register ends up reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rsv_valid | input | 1 | Reserve beat valid |
| rsv_warp | input | WW | Warp of the reserve beat |
| rsv_kind | input | 2 | Issue origin: 0 primary, 1 intra co-issue, 2 inter donor |
| rsv_dst | input | NUM_DST*RW | Destination register numbers, entry 0 in the low bits |
| rel_valid | input | 1 | Release beat valid |
| rel_warp | input | WW | Warp of the release beat |
| rel_tagged | input | 1 | The release carries an explicit slot |
| rel_slot | input | 2 | Explicit slot when tagged |
| rel_intra | input | 1 | Untagged release came from intra-warp co-issue |
| rel_reg | input | RW | Register number released |
| q_warp | input | WW | Warp of the hazard query |
| q_slot | input | 2 | Slot of the hazard query |
| q_dst | input | NUM_DST*RW | Query destination registers |
| q_src | input | NUM_SRC*RW | Query source registers |
| q_pred | input | RW | Query predicate register |
| q_addr | input | 2*RW | Query address registers |
| q_hit | output | 1 | Collision in the named slot |
| warp_pending | output | NUM_WARPS | Either slot of the warp non-empty |
| slot_clean | output | 2*NUM_WARPS | Slot empty, bit 2*w+s |

## Verification
The bench goes after slot confusion. A design that routes intra co-issue or untagged intra releases to slot 0 would leave slot 1 dirty and report a stale pending warp. One whose query ignores the slot would stall on registers held by the other half. It reserves a register twice and releases it once, which catches a reference-counting design that would leave the register stuck. It collides a reserve and a release on the same register in one cycle, which catches a design that applies the release last and loses the reservation. It also queries with zero operands and with a hit only on an address or destination operand, which catches a design that treats register 0 as real or forgets an operand class.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SLOTS = 2;

  typedef enum logic [1:0] {
    ISSUE_PRIMARY = 2'd0,
    ISSUE_INTRA   = 2'd1,
    ISSUE_DONOR   = 2'd2,
    ISSUE_BAD     = 2'd3
  } issue_kind_e;
endpackage

// File: rtl/sb_slot_route.sv
module sb_slot_route
  import sb_pkg::*;
(
  input  issue_kind_e rsv_kind,
  input  logic        rel_tagged,
  input  logic [1:0]  rel_slot,
  input  logic        rel_intra,
  output logic        rsv_slot,
  output logic        rsv_legal,
  output logic        rel_slot_sel,
  output logic        rel_legal
);
  always_comb begin
    rsv_slot  = 1'b0;
    rsv_legal = 1'b1;
    unique case (rsv_kind)
      ISSUE_PRIMARY: rsv_slot = 1'b0;
      ISSUE_INTRA:   rsv_slot = 1'b1;
      ISSUE_DONOR:   rsv_slot = 1'b0;
      default:       rsv_legal = 1'b0;
    endcase
  end

  always_comb begin
    if (rel_tagged) begin
      rel_slot_sel = rel_slot[0];
      rel_legal    = ~rel_slot[1];
    end else begin
      rel_slot_sel = rel_intra;
      rel_legal    = 1'b1;
    end
  end
endmodule

// File: rtl/sb_table.sv
module sb_table #(
  parameter int NW = 8,
  parameter int NR = 64,
  parameter int ND = 2,
  parameter int RW = 6,
  parameter int WW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rsv_en,
  input  logic [WW-1:0]              rsv_warp,
  input  logic                       rsv_slot,
  input  logic [ND-1:0][RW-1:0]      rsv_dst,
  input  logic                       rel_en,
  input  logic [WW-1:0]              rel_warp,
  input  logic                       rel_slot,
  input  logic [RW-1:0]              rel_reg,
  output logic [2*NW-1:0][NR-1:0]    tbl_q
);
  logic [NR-1:0] set_vec;
  logic [NR-1:0] clr_vec;
  logic [WW:0]   rsv_idx;
  logic [WW:0]   rel_idx;

  assign rsv_idx = {rsv_warp, rsv_slot};
  assign rel_idx = {rel_warp, rel_slot};

  always_comb begin
    set_vec = '0;
    for (int d = 0; d < ND; d++) begin
      if (rsv_dst[d] != '0) set_vec[rsv_dst[d]] = 1'b1;
    end
    clr_vec = '0;
    if (rel_reg != '0) clr_vec[rel_reg] = 1'b1;
  end

  for (genvar e = 0; e < 2*NW; e++) begin : g_entry
    localparam logic [WW:0] ENTRY = (WW+1)'(e);
    logic [NR-1:0] row_q;
    logic          take_rsv;
    logic          take_rel;

    assign take_rsv = rsv_en && (rsv_idx == ENTRY);
    assign take_rel = rel_en && (rel_idx == ENTRY);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_q <= '0;
      end else begin
        row_q <= (row_q & ~(take_rel ? clr_vec : '0)) |
                 (take_rsv ? set_vec : '0);
      end
    end

    assign tbl_q[e] = row_q;
  end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
  parameter int NW   = 8,
  parameter int NR   = 64,
  parameter int NOPS = 8,
  parameter int RW   = 6,
  parameter int WW   = 3
) (
  input  logic [2*NW-1:0][NR-1:0] tbl_q,
  input  logic [WW-1:0]           q_warp,
  input  logic [1:0]              q_slot,
  input  logic [NOPS-1:0][RW-1:0] q_ops,
  output logic                    q_hit
);
  logic [NR-1:0]   row;
  logic [NOPS-1:0] op_hit;

  assign row = tbl_q[{q_warp, q_slot[0]}];

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    assign op_hit[o] = (q_ops[o] != '0) && row[q_ops[o]];
  end

  assign q_hit = ~q_slot[1] & (|op_hit);
endmodule

// File: rtl/dual_slot_scoreboard.sv
module dual_slot_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 64,
  parameter int NUM_DST   = 2,
  parameter int NUM_SRC   = 3,
  localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rsv_valid,
  input  logic [WW-1:0]           rsv_warp,
  input  logic [1:0]              rsv_kind,
  input  logic [NUM_DST*RW-1:0]   rsv_dst,
  input  logic                    rel_valid,
  input  logic [WW-1:0]           rel_warp,
  input  logic                    rel_tagged,
  input  logic [1:0]              rel_slot,
  input  logic                    rel_intra,
  input  logic [RW-1:0]           rel_reg,
  input  logic [WW-1:0]           q_warp,
  input  logic [1:0]              q_slot,
  input  logic [NUM_DST*RW-1:0]   q_dst,
  input  logic [NUM_SRC*RW-1:0]   q_src,
  input  logic [RW-1:0]           q_pred,
  input  logic [2*RW-1:0]         q_addr,
  output logic                    q_hit,
  output logic [NUM_WARPS-1:0]    warp_pending,
  output logic [2*NUM_WARPS-1:0]  slot_clean
);
  localparam int NOPS = NUM_DST + NUM_SRC + 3;

  logic                              rsv_slot_w, rsv_ok_w;
  logic                              rel_slot_w, rel_ok_w;
  logic [2*NUM_WARPS-1:0][NUM_REGS-1:0] tbl_q;
  logic [NOPS-1:0][RW-1:0]           q_ops;

  sb_slot_route u_route (
    .rsv_kind     (issue_kind_e'(rsv_kind)),
    .rel_tagged   (rel_tagged),
    .rel_slot     (rel_slot),
    .rel_intra    (rel_intra),
    .rsv_slot     (rsv_slot_w),
    .rsv_legal    (rsv_ok_w),
    .rel_slot_sel (rel_slot_w),
    .rel_legal    (rel_ok_w)
  );

  sb_table #(
    .NW (NUM_WARPS), .NR (NUM_REGS), .ND (NUM_DST), .RW (RW), .WW (WW)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsv_en   (rsv_valid && rsv_ok_w),
    .rsv_warp (rsv_warp),
    .rsv_slot (rsv_slot_w),
    .rsv_dst  (rsv_dst),
    .rel_en   (rel_valid && rel_ok_w),
    .rel_warp (rel_warp),
    .rel_slot (rel_slot_w),
    .rel_reg  (rel_reg),
    .tbl_q    (tbl_q)
  );

  assign q_ops = {q_addr, q_pred, q_src, q_dst};

  sb_hazard #(
    .NW (NUM_WARPS), .NR (NUM_REGS), .NOPS (NOPS), .RW (RW), .WW (WW)
  ) u_hazard (
    .tbl_q  (tbl_q),
    .q_warp (q_warp),
    .q_slot (q_slot),
    .q_ops  (q_ops),
    .q_hit  (q_hit)
  );

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_status
    assign slot_clean[2*w]   = ~|tbl_q[2*w];
    assign slot_clean[2*w+1] = ~|tbl_q[2*w+1];
    assign warp_pending[w]   = (|tbl_q[2*w]) | (|tbl_q[2*w+1]);
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 64,
  parameter int NUM_DST   = 2,
  parameter int NUM_SRC   = 3,
  parameter int WW        = 3,
  parameter int RW        = 6
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              rsv_valid,
  input logic [WW-1:0]                     rsv_warp,
  input logic [1:0]                        rsv_kind,
  input logic [NUM_DST*RW-1:0]             rsv_dst,
  input logic                              rel_valid,
  input logic [WW-1:0]                     rel_warp,
  input logic                              rel_tagged,
  input logic [1:0]                        rel_slot,
  input logic                              rel_intra,
  input logic [RW-1:0]                     rel_reg,
  input logic [1:0]                        q_slot,
  input logic [NUM_DST*RW-1:0]             q_dst,
  input logic [NUM_SRC*RW-1:0]             q_src,
  input logic [RW-1:0]                     q_pred,
  input logic [2*RW-1:0]                   q_addr,
  input logic                              q_hit,
  input logic [NUM_WARPS-1:0]              warp_pending,
  input logic [2*NUM_WARPS-1:0]            slot_clean,
  input logic [2*NUM_WARPS-1:0][NUM_REGS-1:0] tbl_q
);
  logic [RW-1:0] d0;
  logic          rel_side;
  assign d0       = rsv_dst[RW-1:0];
  assign rel_side = rel_tagged ? rel_slot[0] : rel_intra;

  // R2: a legal reserve of a nonzero register lands in its routed slot
  a_r2_reserve_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && rsv_kind != 2'd3 && d0 != '0) |=>
      tbl_q[{$past(rsv_warp), $past(rsv_kind == 2'd1)}][$past(d0)]);

  // R3: reserve kind code 3 is outside the contract
  a_r3_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_valid |-> rsv_kind != 2'd3);

  // R5: a release with no reserve beside it empties that register
  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rsv_valid && !(rel_tagged && rel_slot[1]) && rel_reg != '0) |=>
      !tbl_q[{$past(rel_warp), $past(rel_side)}][$past(rel_reg)]);

  // R6: tagged release slot must be 0 or 1
  a_r6_rel_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && rel_tagged) |-> !rel_slot[1]);

  // R7: an all-zero operand set never collides
  a_r7_zero_ops_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (q_dst == '0 && q_src == '0 && q_pred == '0 && q_addr == '0) |-> !q_hit);

  // R8: query slot must be 0 or 1
  a_r8_query_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !q_slot[1]);

  // R9: status holds when no beat arrives
  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsv_valid && !rel_valid) |=> ($stable(slot_clean) && $stable(warp_pending)));

  // R10: same-register reserve and release in slot 0 leaves it reserved
  a_r10_reserve_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && rsv_kind == 2'd0 && rel_valid && rel_tagged && rel_slot == 2'd0 &&
     rsv_warp == rel_warp && d0 == rel_reg && d0 != '0) |=>
      tbl_q[{$past(rsv_warp), 1'b0}][$past(d0)]);
endmodule

bind dual_slot_scoreboard sb_checker #(
  .NUM_WARPS (NUM_WARPS), .NUM_REGS (NUM_REGS), .NUM_DST (NUM_DST),
  .NUM_SRC (NUM_SRC), .WW (WW), .RW (RW)
) u_sb_checker (
  .clk (clk), .rst_n (rst_n),
  .rsv_valid (rsv_valid), .rsv_warp (rsv_warp), .rsv_kind (rsv_kind), .rsv_dst (rsv_dst),
  .rel_valid (rel_valid), .rel_warp (rel_warp), .rel_tagged (rel_tagged),
  .rel_slot (rel_slot), .rel_intra (rel_intra), .rel_reg (rel_reg),
  .q_slot (q_slot), .q_dst (q_dst), .q_src (q_src), .q_pred (q_pred), .q_addr (q_addr),
  .q_hit (q_hit), .warp_pending (warp_pending), .slot_clean (slot_clean), .tbl_q (tbl_q)
);

// File: tb/tb_dual_slot_scoreboard.sv
module tb_dual_slot_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NR = 32;
  localparam int ND = 2;
  localparam int NS = 3;
  localparam int RW = 5;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsv_valid = 0, rel_valid = 0, rel_tagged = 0, rel_intra = 0;
  logic [WW-1:0] rsv_warp = 0, rel_warp = 0, q_warp = 0;
  logic [1:0] rsv_kind = 0, rel_slot = 0, q_slot = 0;
  logic [ND*RW-1:0] rsv_dst = 0, q_dst = 0;
  logic [NS*RW-1:0] q_src = 0;
  logic [RW-1:0] rel_reg = 0, q_pred = 0;
  logic [2*RW-1:0] q_addr = 0;
  logic q_hit;
  logic [NW-1:0] warp_pending;
  logic [2*NW-1:0] slot_clean;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit ref_sb [NW][2][NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_slot_scoreboard #(
    .NUM_WARPS (NW), .NUM_REGS (NR), .NUM_DST (ND), .NUM_SRC (NS)
  ) dut (.*);

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_hit();
    int ops[$];
    int s;
    s = q_slot;
    if (s > 1) return 0;
    for (int i = 0; i < ND; i++) ops.push_back(q_dst[i*RW +: RW]);
    for (int i = 0; i < NS; i++) ops.push_back(q_src[i*RW +: RW]);
    ops.push_back(q_pred);
    ops.push_back(q_addr[RW-1:0]);
    ops.push_back(q_addr[2*RW-1:RW]);
    foreach (ops[i]) if (ops[i] != 0 && ref_sb[q_warp][s][ops[i]]) return 1;
    return 0;
  endfunction

  function automatic logic [2*NW-1:0] ref_clean();
    logic [2*NW-1:0] c;
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 2; s++) begin
        c[2*w+s] = 1'b1;
        for (int r = 0; r < NR; r++) if (ref_sb[w][s][r]) c[2*w+s] = 1'b0;
      end
    return c;
  endfunction

  function automatic logic [NW-1:0] ref_pending();
    logic [2*NW-1:0] c;
    logic [NW-1:0] p;
    c = ref_clean();
    for (int w = 0; w < NW; w++) p[w] = !(c[2*w] && c[2*w+1]);
    return p;
  endfunction

  // one clock: model takes the beats held over the edge, then compare
  task automatic cyc();
    int s;
    @(posedge clk);
    if (rst_n) begin
      if (rel_valid && !(rel_tagged && rel_slot > 1)) begin
        s = rel_tagged ? int'(rel_slot) : (rel_intra ? 1 : 0);
        if (rel_reg != 0) ref_sb[rel_warp][s][rel_reg] = 0;
      end
      if (rsv_valid && rsv_kind != 3) begin
        s = (rsv_kind == 1) ? 1 : 0;
        for (int i = 0; i < ND; i++)
          if (rsv_dst[i*RW +: RW] != 0) ref_sb[rsv_warp][s][rsv_dst[i*RW +: RW]] = 1;
      end
    end
    @(negedge clk);
    if (rst_n) begin
      check("R9 per-cycle slot_clean", slot_clean, ref_clean());
      check("R9 per-cycle warp_pending", warp_pending, ref_pending());
      check("R7 per-cycle q_hit", q_hit, ref_hit());
    end
  endtask

  task automatic idle();
    rsv_valid = 0; rel_valid = 0;
  endtask

  task automatic reserve(int w, int kind, int da, int db);
    rsv_valid = 1; rsv_warp = WW'(w); rsv_kind = 2'(kind);
    rsv_dst = {RW'(db), RW'(da)};
  endtask

  task automatic release_t(int w, int s, int r);
    rel_valid = 1; rel_warp = WW'(w); rel_tagged = 1; rel_slot = 2'(s);
    rel_intra = 0; rel_reg = RW'(r);
  endtask

  task automatic release_u(int w, bit intra, int r);
    rel_valid = 1; rel_warp = WW'(w); rel_tagged = 0; rel_slot = 0;
    rel_intra = intra; rel_reg = RW'(r);
  endtask

  task automatic query(int w, int s, int d, int src, int p, int a);
    q_warp = WW'(w); q_slot = 2'(s);
    q_dst = {RW'(0), RW'(d)};
    q_src = {RW'(0), RW'(0), RW'(src)};
    q_pred = RW'(p);
    q_addr = {RW'(a), RW'(0)};
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    @(negedge clk); rst_n = 1;
    cyc();
    check("R1 reset clean", slot_clean, 8'hFF);
    check("R1 reset pending", warp_pending, 4'h0);

    reserve(1, 0, 0, 5); cyc(); idle();
    check("R2 reserve slot0 w1", slot_clean, 8'hFB);
    check("R9 pending w1", warp_pending, 4'b0010);
    query(1, 0, 0, 5, 0, 0);
    check("R7 source hit", q_hit, 1);
    query(1, 1, 0, 5, 0, 0);
    check("R8 other slot quiet", q_hit, 0);

    reserve(1, 1, 9, 7); cyc(); idle();
    check("R3 intra to slot1", slot_clean, 8'hF3);
    reserve(2, 2, 0, 3); cyc(); idle();
    check("R3 donor to slot0", slot_clean, 8'hE3);
    check("R9 pending w1 w2", warp_pending, 4'b0110);

    reserve(1, 0, 5, 5); cyc(); idle();
    check("R4 repeat reserve", slot_clean, 8'hE3);
    release_t(1, 0, 5); cyc(); idle();
    check("R4 one release clears", slot_clean, 8'hE7);

    release_t(1, 0, 7); cyc(); idle();
    check("R5 absent release", slot_clean, 8'hE7);
    query(1, 1, 0, 0, 7, 0);
    check("R5 other slot kept", q_hit, 1);

    release_u(1, 1, 7); cyc(); idle();
    query(1, 1, 0, 0, 7, 0);
    check("R6 untagged intra slot1", q_hit, 0);
    check("R6 slot1 still has 9", slot_clean, 8'hE7);
    release_u(1, 1, 9); cyc(); idle();
    check("R6 slot1 drained", slot_clean, 8'hEF);
    release_u(2, 0, 3); cyc(); idle();
    check("R6 untagged primary slot0", slot_clean, 8'hFF);
    check("R9 no pending", warp_pending, 4'h0);

    reserve(0, 0, 0, 0); cyc(); idle();
    check("R2 zero dst skipped", slot_clean, 8'hFF);

    reserve(3, 0, 4, 0); release_t(3, 0, 4); cyc(); idle();
    check("R10 reserve wins", slot_clean, 8'hBF);
    check("R9 pending w3", warp_pending, 4'b1000);
    query(3, 0, 0, 0, 0, 4);
    check("R7 address hit", q_hit, 1);
    query(3, 0, 4, 0, 0, 0);
    check("R7 destination hit", q_hit, 1);
    query(3, 0, 0, 0, 0, 0);
    check("R7 zero operands", q_hit, 0);
    release_t(3, 0, 4); cyc(); idle();
    check("R5 release after collide", slot_clean, 8'hFF);

    for (int k = 0; k < 4000; k++) begin
      rsv_valid = 1'($urandom % 2);
      rsv_warp = WW'($urandom % NW);
      rsv_kind = 2'($urandom % 3);
      rsv_dst = {RW'($urandom % 8), RW'($urandom % 8)};
      rel_valid = 1'($urandom % 2);
      rel_warp = WW'($urandom % NW);
      rel_tagged = 1'($urandom % 2);
      rel_slot = 2'($urandom % 2);
      rel_intra = 1'($urandom % 2);
      rel_reg = RW'($urandom % 8);
      q_warp = WW'($urandom % NW);
      q_slot = 2'($urandom % 2);
      q_dst = {RW'($urandom % 8), RW'($urandom % 8)};
      q_src = {RW'($urandom % 8), RW'($urandom % 8), RW'($urandom % 8)};
      q_pred = RW'($urandom % 8);
      q_addr = {RW'($urandom % 8), RW'($urandom % 8)};
      if (k % 5 == 0) begin
        q_dst = 0; q_src = {RW'(0), RW'(0), RW'($urandom % 8)}; q_pred = 0; q_addr = 0;
      end
      cyc();
    end
    idle();
    cyc();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule